// File: doc/BRIEF.md
# Coded NRZ Transmit Framer

The framer turns a stream of host message bytes into a continuous serial line of 11-bit code words for a baseband loop modem. The host's own UART output has already been turned back into plain 8-bit bytes, with its start, stop and parity bits removed. When request-to-send is active and the host's first start bit is seen, the framer loads a preamble code word into its shift register on the next clock edge. Line output therefore begins while the host's first byte is still arriving. From then on one code word follows another with no gap. Each word is shifted out least significant bit first, and each bit lasts a fixed number of reference ticks.

A small field tracker decides what each byte becomes. While the message is still in its preamble field, every 0xFF byte is sent as one of two reserved preamble words, 11'b01010101010 or 11'b10101010101. The choice depends on the bit 0 of the word just sent, so the preamble is an unbroken run of alternating bits. The first byte that is not 0xFF is the start delimiter. It and every byte after it, including 0xFF, go through an external byte-to-code-word table. The table address is formed from the byte and the bit 0 of the previous word. If a word boundary arrives with no byte waiting, a preamble word is inserted as filler and an underrun flag is raised. When request-to-send is low at a boundary and nothing is pending, the line goes quiet.

Top module: `nrz_tx_framer`

## Requirements
- R1: After reset, and whenever the framer is idle, `ser_o`, `tx_active_o` and `underrun_o` are all low.
- R2: While idle, a `host_start_i` pulse with `rts_i` high raises `tx_active_o` on the next cycle, and the first word sent is 11'b01010101010. A `host_start_i` pulse with `rts_i` low is ignored, and so is a `byte_valid_i` pulse while idle.
- R3: Each line bit is held for REF_DIV `ref_tick_i` pulses. Words are sent least significant bit first, and each word follows the previous one with no gap.
- R4: A preamble word is 11'b10101010101 when bit 0 of the previous word is 0, and 11'b01010101010 when it is 1. After a start, therefore, preamble words alternate.
- R5: In the preamble field, each 0xFF byte is sent as a preamble word chosen by R4.
- R6: The first byte that is not 0xFF is sent as `lut_word_i` and moves the tracker to the data field. In the data field every byte, 0xFF included, is sent as `lut_word_i`.
- R7: `lut_addr_o` is {bit 0 of the previous word, pending byte}, with bit 8 holding that bit 0 of the previous word.
- R8: If no byte is pending at a word boundary while `rts_i` is high, a preamble word chosen by R4 is sent. `underrun_o` then goes high and stays high until a host byte is loaded.
- R9: A byte that is pending at a boundary is sent even if `rts_i` is low. When `rts_i` is low and no byte is pending at a boundary, the framer goes idle after the last word ends, and the next start begins a fresh preamble field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle strobe at the reference rate (460.8 kHz) |
| rts_i | input | 1 | Request-to-send from the host |
| host_start_i | input | 1 | Pulse when a host UART start bit is detected |
| byte_valid_i | input | 1 | Host byte strobe |
| byte_i | input | 8 | Host byte, parity and framing removed |
| lut_addr_o | output | 9 | Table address: {bit 0 of previous word, byte} |
| lut_word_i | input | 11 | Code word returned by the external table |
| ser_o | output | 1 | Serial line output |
| tx_active_o | output | 1 | High while words are being sent |
| underrun_o | output | 1 | High while a filler word inserted for lack of a byte is being sent |

## Verification
The checker watches the following on every cycle:
- the quiet line in idle;
- the one-cycle start response, and the absence of any start without request-to-send;
- a line level that changes only on a bit tick;
- underrun rising only at a word boundary;
- the return to idle happening only at a boundary where request-to-send is low.

The actual word contents need the bench's directed sessions, which check them against a table modelled in the bench. These contents are the preamble alternation, the split between 0xFF preamble bytes and 0xFF data bytes, the table address bit taken from the previous word, the filler word and the draining of a pending byte.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;
  localparam int unsigned CW_W   = 11;
  localparam int unsigned DB_W   = 8;
  localparam int unsigned ADDR_W = DB_W + 1;

  // reserved preamble words; both have equal end bits
  localparam logic [CW_W-1:0] PRE_WORD_LO = 11'b01010101010;
  localparam logic [CW_W-1:0] PRE_WORD_HI = 11'b10101010101;
  localparam logic [DB_W-1:0] FILL_BYTE   = 8'hFF;

  typedef enum logic [1:0] {
    FLD_IDLE = 2'd0,
    FLD_PRE  = 2'd1,
    FLD_DATA = 2'd2
  } fld_e;
endpackage

// File: rtl/nrz_bit_divider.sv
module nrz_bit_divider #(
  parameter int unsigned REF_DIV = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic restart_i,
  output logic bit_tick_o
);
  localparam int unsigned CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en     = restart_i | ref_tick_i;
  assign bit_tick_o = ref_tick_i & ~restart_i & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (ref_tick_i) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nrz_word_shifter.sv
module nrz_word_shifter
  import nrz_tx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            bit_tick_i,
  input  logic            load_i,
  input  logic [CW_W-1:0] word_i,
  input  logic            clear_i,
  output logic            ser_o,
  output logic            word_end_o,
  output logic            prev_lsb_o
);
  localparam int unsigned CNT_W = $clog2(CW_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CW_W - 1);

  logic [CW_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lsb_q, lsb_d;
  logic             upd_en;

  assign word_end_o = active_i & bit_tick_i & (cnt_q == CNT_LAST);
  assign ser_o      = sh_q[0];
  assign prev_lsb_o = lsb_q;
  assign upd_en     = clear_i | load_i | (active_i & bit_tick_i);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    lsb_d = lsb_q;
    if (clear_i) begin
      sh_d  = '0;
      cnt_d = '0;
      lsb_d = 1'b1;
    end else if (load_i) begin
      sh_d  = word_i;
      cnt_d = '0;
      lsb_d = word_i[0];
    end else if (active_i && bit_tick_i) begin
      sh_d  = {1'b0, sh_q[CW_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      lsb_q <= 1'b1;
    end else if (upd_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      lsb_q <= lsb_d;
    end
  end
endmodule

// File: rtl/nrz_field_tracker.sv
module nrz_field_tracker
  import nrz_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rts_i,
  input  logic              host_start_i,
  input  logic              byte_valid_i,
  input  logic [DB_W-1:0]   byte_i,
  input  logic              word_end_i,
  input  logic              prev_lsb_i,
  input  logic [CW_W-1:0]   lut_word_i,
  output logic [ADDR_W-1:0] lut_addr_o,
  output logic              load_o,
  output logic [CW_W-1:0]   word_o,
  output logic              restart_o,
  output logic              clear_o,
  output logic              active_o,
  output logic              underrun_o
);
  fld_e            fld_q, fld_d;
  logic [DB_W-1:0] hold_q, hold_d;
  logic            full_q, full_d;
  logic            unr_q, unr_d;
  logic [CW_W-1:0] pre_word;

  assign pre_word   = prev_lsb_i ? PRE_WORD_LO : PRE_WORD_HI;
  assign lut_addr_o = {prev_lsb_i, hold_q};
  assign active_o   = (fld_q != FLD_IDLE);
  assign underrun_o = unr_q;

  always_comb begin
    fld_d     = fld_q;
    hold_d    = hold_q;
    full_d    = full_q;
    unr_d     = unr_q;
    load_o    = 1'b0;
    word_o    = pre_word;
    restart_o = 1'b0;
    clear_o   = 1'b0;
    if (fld_q == FLD_IDLE) begin
      full_d = 1'b0;
      unr_d  = 1'b0;
      if (rts_i && host_start_i) begin
        load_o    = 1'b1;
        word_o    = PRE_WORD_LO;
        restart_o = 1'b1;
        fld_d     = FLD_PRE;
      end
    end else begin
      if (word_end_i) begin
        if (full_q) begin
          load_o = 1'b1;
          full_d = 1'b0;
          unr_d  = 1'b0;
          if (fld_q == FLD_PRE && hold_q == FILL_BYTE) begin
            word_o = pre_word;
          end else begin
            word_o = lut_word_i;
            fld_d  = FLD_DATA;
          end
        end else if (rts_i) begin
          load_o = 1'b1;
          word_o = pre_word;
          unr_d  = 1'b1;
        end else begin
          clear_o = 1'b1;
          unr_d   = 1'b0;
          fld_d   = FLD_IDLE;
        end
      end
      if (byte_valid_i && !clear_o) begin
        hold_d = byte_i;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q  <= FLD_IDLE;
      hold_q <= '0;
      full_q <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      hold_q <= hold_d;
      full_q <= full_d;
      unr_q  <= unr_d;
    end
  end
endmodule

// File: rtl/nrz_tx_framer.sv
module nrz_tx_framer
  import nrz_tx_pkg::*;
#(
  parameter int unsigned REF_DIV = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              rts_i,
  input  logic              host_start_i,
  input  logic              byte_valid_i,
  input  logic [DB_W-1:0]   byte_i,
  output logic [ADDR_W-1:0] lut_addr_o,
  input  logic [CW_W-1:0]   lut_word_i,
  output logic              ser_o,
  output logic              tx_active_o,
  output logic              underrun_o
);
  logic            bit_tick;
  logic            restart;
  logic            load;
  logic [CW_W-1:0] load_word;
  logic            clear;
  logic            active;
  logic            word_end;
  logic            prev_lsb;

  nrz_bit_divider #(.REF_DIV(REF_DIV)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .restart_i  (restart),
    .bit_tick_o (bit_tick)
  );

  nrz_field_tracker u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rts_i        (rts_i),
    .host_start_i (host_start_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .word_end_i   (word_end),
    .prev_lsb_i   (prev_lsb),
    .lut_word_i   (lut_word_i),
    .lut_addr_o   (lut_addr_o),
    .load_o       (load),
    .word_o       (load_word),
    .restart_o    (restart),
    .clear_o      (clear),
    .active_o     (active),
    .underrun_o   (underrun_o)
  );

  nrz_word_shifter u_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .bit_tick_i (bit_tick),
    .load_i     (load),
    .word_i     (load_word),
    .clear_i    (clear),
    .ser_o      (ser_o),
    .word_end_o (word_end),
    .prev_lsb_o (prev_lsb)
  );

  assign tx_active_o = active;
endmodule

// File: rtl/nrz_tx_framer_chk.sv
module nrz_tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rts_i,
  input logic host_start_i,
  input logic active_i,
  input logic ser_i,
  input logic underrun_i,
  input logic bit_tick_i,
  input logic word_end_i
);
  AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!ser_i && !underrun_i)); // R1
  AST_START_ON_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && rts_i && host_start_i) |=> active_i); // R2
  AST_NO_START_WITHOUT_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !(rts_i && host_start_i)) |=> !active_i); // R2
  AST_LINE_HELD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !$past(bit_tick_i)) |-> (ser_i == $past(ser_i))); // R3
  AST_UNDERRUN_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_i) |-> $past(word_end_i)); // R8
  AST_IDLE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |-> ($past(word_end_i) && !$past(rts_i))); // R9
endmodule

bind nrz_tx_framer nrz_tx_framer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rts_i        (rts_i),
  .host_start_i (host_start_i),
  .active_i     (tx_active_o),
  .ser_i        (ser_o),
  .underrun_i   (underrun_o),
  .bit_tick_i   (bit_tick),
  .word_end_i   (word_end)
);

// File: tb/nrz_tx_framer_tb.sv
`timescale 1ns/1ps
module nrz_tx_framer_tb_top;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rts, hstart, bvalid;
  logic [7:0]  bdata;
  logic [8:0]  laddr;
  logic [10:0] lword;
  logic        ser, active, unr;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // bench model of the external table
  assign lword = 11'h600 ^ {2'b00, laddr};

  nrz_tx_framer #(.REF_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(1'b1), .rts_i(rts),
    .host_start_i(hstart), .byte_valid_i(bvalid), .byte_i(bdata),
    .lut_addr_o(laddr), .lut_word_i(lword), .ser_o(ser),
    .tx_active_o(active), .underrun_o(unr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // collects one word, one bit every DIV cycles, starting in bit 0
  task automatic get_word(input bit give, input logic [7:0] b,
                          output logic [10:0] w, output logic uflag);
    int glitch = 0;
    for (int i = 0; i < 11; i++) begin
      if (i == 2 && give) begin bvalid = 1'b1; bdata = b; end
      if (i == 4) bvalid = 1'b0;
      w[i] = ser;
      if (i == 5) uflag = unr;
      for (int k = 1; k < DIV; k++) begin
        @(negedge clk);
        if (ser != w[i]) glitch++;
      end
      @(negedge clk);
    end
    chk(glitch == 0, "R3 bit held for full period", glitch, 0);
  endtask

  task automatic start_tx();
    rts = 1'b1;
    @(negedge clk);
    hstart = 1'b1;
    @(negedge clk);
    hstart = 1'b0;
    chk(active == 1'b1, "R2 active next cycle", active, 1);
  endtask

  task automatic test_reset();
    chk(ser == 1'b0, "R1 reset ser", ser, 0);
    chk(active == 1'b0, "R1 reset active", active, 0);
    chk(unr == 1'b0, "R1 reset underrun", unr, 0);
  endtask

  task automatic test_main_flow();
    logic [10:0] w;
    logic u;
    start_tx();
    get_word(1, 8'hFF, w, u); chk(w == 11'd682, "R2 first auto word", w, 682);
    get_word(1, 8'hFF, w, u); chk(w == 11'd1365, "R4 R5 FF preamble alt", w, 1365);
    get_word(1, 8'h82, w, u); chk(w == 11'd682, "R4 R5 FF preamble alt", w, 682);
    get_word(1, 8'hFF, w, u); chk(w == 11'h682, "R6 delimiter encoded", w, 'h682);
    get_word(1, 8'h12, w, u); chk(w == 11'h6FF, "R6 FF data encoded", w, 'h6FF);
    get_word(0, 8'h00, w, u); chk(w == 11'h712, "R7 addr uses prev bit0", w, 'h712);
    get_word(1, 8'h34, w, u);
    chk(w == 11'd1365, "R8 filler word", w, 1365);
    chk(u == 1'b1, "R8 underrun high", u, 1);
    rts = 1'b0;
    get_word(0, 8'h00, w, u);
    chk(w == 11'h734, "R9 pending byte drained", w, 'h734);
    chk(u == 1'b0, "R8 underrun cleared", u, 0);
    chk(active == 1'b0, "R9 idle after last word", active, 0);
    chk(ser == 1'b0, "R1 idle line low", ser, 0);
  endtask

  task automatic test_restart();
    logic [10:0] w;
    logic u;
    rts = 1'b0;
    hstart = 1'b1; bvalid = 1'b1; bdata = 8'hFF;
    @(negedge clk);
    hstart = 1'b0; bvalid = 1'b0;
    repeat (20) @(negedge clk);
    chk(active == 1'b0, "R2 start ignored without rts", active, 0);
    chk(ser == 1'b0, "R2 line quiet without rts", ser, 0);
    start_tx();
    get_word(1, 8'h86, w, u); chk(w == 11'd682, "R9 fresh session first word", w, 682);
    get_word(1, 8'hFF, w, u); chk(w == 11'h686, "R6 immediate delimiter", w, 'h686);
    rts = 1'b0;
    get_word(0, 8'h00, w, u); chk(w == 11'h6FF, "R6 FF as data", w, 'h6FF);
    chk(active == 1'b0, "R9 idle again", active, 0);
    chk(unr == 1'b0, "R1 idle underrun low", unr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rts = 1'b0; hstart = 1'b0; bvalid = 1'b0; bdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_main_flow();
    repeat (8) @(negedge clk);
    test_restart();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule